// File: doc/BRIEF.md
# Digital PLL Frequency Lock Detector

This block decides whether a recovered-clock oscillator is running close enough to its target frequency for the data phase detector to take over the loop. The target is twenty times the reference clock. The oscillator clock is first divided by twenty inside its own clock domain. The ticks of that divided clock are then counted over a fixed window of reference cycles. The count is compared with the window length, within a tolerance that the caller picks: ±500 ppm or ±2000 ppm.

The lock output reports the result of that comparison. A second output steers the charge pump. It selects the reference-based phase-frequency comparator while the oscillator is out of the window, and the bang-bang data phase detector once the oscillator is in lock. Measurement never stops. A locked loop that drifts out of the window is handed back to the reference comparator after the next measurement. Acquiring lock takes two consecutive in-window measurements, while a single failed measurement drops it. The oscillator count crosses into the reference domain through a Gray-coded synchronizer.

Top module: `freq_lock_det`

## Requirements
- R1: While rst_ni is low and after its release, lock_o is 0 and pd_sel_o is 0.
- R2: The oscillator clock divided by DIV (20) is counted over each window of 2^WIN_LOG2 reference cycles. An oscillator at exactly DIV times the reference frequency is judged in-window in either range. The first window after reset is discarded.
- R3: lock_o rises only after two consecutive in-window measurements. At the middle of the third window after reset lock_o is still 0, and at the middle of the fourth window it is 1.
- R4: While locked, a single out-of-window measurement clears lock_o at that measurement.
- R5: With range_wide_i = 0, the tolerance is floor(2^WIN_LOG2 · 500 / 10^6) counts, so a +1000 ppm oscillator never reaches lock.
- R6: With range_wide_i = 1, the tolerance is floor(2^WIN_LOG2 · 2000 / 10^6) counts, so a +1000 ppm oscillator reaches lock.
- R7: pd_sel_o is 1 (data phase detector) exactly while locked, and 0 (reference phase-frequency comparator) otherwise.
- R8: Monitoring continues after a loss of lock. Once the oscillator returns to the window, lock_o is regained after two in-window measurements and not after one.
- R9: The window is symmetric. A −1000 ppm oscillator fails the narrow range and passes the wide range.
- R10: range_wide_i is sampled at each measurement. Switching from wide to narrow while locked at +1000 ppm clears lock_o at the next measurement.
- R11: A stopped oscillator clock is out-of-window. It clears lock_o and keeps it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock; the lock logic runs on it |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| clk_vco_i | input | 1 | Oscillator clock, nominally DIV times the reference |
| range_wide_i | input | 1 | 0: ±500 ppm window, 1: ±2000 ppm window |
| lock_o | output | 1 | Lock alarm: 1 while the oscillator is in the window |
| pd_sel_o | output | 1 | Charge-pump source: 0 phase-frequency comparator, 1 data phase detector |

## Verification
The hardest situations to reach from the ports depend on window boundaries. One is a lock that must not yet be granted after a single good window that follows a bad one. The other is a range change that must act at exactly the next measurement. The bench counts reference cycles from the release of reset, so it always knows where each window starts. It changes the oscillator period or the range only at the middle of a window. This leaves a single mixed window whose outcome is known from how far the offset is from the tolerance. The bench then samples at later mid-window points, where the result no longer depends on synchronizer latency. A stopped oscillator clock is driven as the extreme out-of-window case.

// File: rtl/flock_pkg.sv
package flock_pkg;
  typedef enum logic {
    SRC_PFC = 1'b0,
    SRC_BB  = 1'b1
  } loop_src_e;
endpackage

// File: rtl/vco_tick_cnt.sv
module vco_tick_cnt #(
  parameter int DIV = 20,
  parameter int CW  = 16
) (
  input  logic          clk_vco_i,
  input  logic          rst_ni,
  output logic [CW-1:0] gray_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q;
  logic [CW-1:0] bin_q, bin_nxt;
  logic [CW-1:0] gray_q;
  logic          tick;

  assign tick    = (pre_q == PW'(DIV - 1));
  assign bin_nxt = bin_q + CW'(1);

  always_ff @(posedge clk_vco_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + PW'(1);
      if (tick) begin
        bin_q  <= bin_nxt;
        gray_q <= bin_nxt ^ (bin_nxt >> 1);
      end
    end
  end

  assign gray_o = gray_q;

  // R2: the crossing code moves by at most one bit per oscillator edge
  p_gray_one_bit_r2: assert property (@(posedge clk_vco_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int CW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] gray_i,
  output logic [CW-1:0] bin_o
);
  logic [CW-1:0] sync_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= gray_i;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_comb begin
    bin_o[CW-1] = sync_q[STAGES-1][CW-1];
    for (int i = CW - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ sync_q[STAGES-1][i];
  end
endmodule

// File: rtl/win_meter.sv
module win_meter #(
  parameter int WIN_LOG2 = 14,
  parameter int CW       = 16,
  parameter int TOL_N    = 8,
  parameter int TOL_W    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] vco_bin_i,
  input  logic          range_wide_i,
  output logic          meas_vld_o,
  output logic          in_win_o
);
  localparam int WIN = 1 << WIN_LOG2;

  logic [WIN_LOG2-1:0] win_q;
  logic [CW-1:0]       prev_q, delta;
  logic                primed_q, vld_q, in_q, win_end;
  logic signed [CW:0]  dev;
  logic [CW:0]         mag, tol;

  assign win_end = &win_q;
  assign delta   = vco_bin_i - prev_q;
  assign dev     = $signed({1'b0, delta}) - $signed((CW+1)'(WIN));
  assign mag     = dev[CW] ? (CW+1)'(-dev) : (CW+1)'(dev);
  assign tol     = range_wide_i ? (CW+1)'(TOL_W) : (CW+1)'(TOL_N);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= '0;
      prev_q   <= '0;
      primed_q <= 1'b0;
      vld_q    <= 1'b0;
      in_q     <= 1'b0;
    end else begin
      win_q <= win_q + WIN_LOG2'(1);
      vld_q <= 1'b0;
      if (win_end) begin
        prev_q   <= vco_bin_i;
        primed_q <= 1'b1;
        vld_q    <= primed_q;       // first window after reset is discarded
        in_q     <= (mag <= tol);
      end
    end
  end

  assign meas_vld_o = vld_q;
  assign in_win_o   = in_q;

  // R2: one verdict strobe per window
  p_single_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import flock_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      meas_vld_i,
  input  logic      in_win_i,
  output logic      lock_o,
  output loop_src_e src_o
);
  logic      lock_q, pass_q;
  loop_src_e src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      pass_q <= 1'b0;
      src_q  <= SRC_PFC;
    end else if (meas_vld_i) begin
      if (!in_win_i) begin
        lock_q <= 1'b0;
        pass_q <= 1'b0;
        src_q  <= SRC_PFC;
      end else if (!lock_q) begin
        if (pass_q) begin
          lock_q <= 1'b1;
          pass_q <= 1'b0;
          src_q  <= SRC_BB;
        end else begin
          pass_q <= 1'b1;
        end
      end
    end
  end

  assign lock_o = lock_q;
  assign src_o  = src_q;

  // R4: one failed verdict drops lock
  p_fail_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_vld_i && !in_win_i |=> !lock_q);
  // R3: lock is only granted on a passing verdict
  p_rise_on_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(meas_vld_i && in_win_i));
  // R8: lock state moves only at verdicts
  p_hold_between_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !meas_vld_i |=> $stable(lock_q));
  // R7: steering source follows lock
  p_src_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q == SRC_BB) == lock_q);
endmodule

// File: rtl/freq_lock_det.sv
module freq_lock_det
  import flock_pkg::*;
#(
  parameter int WIN_LOG2   = 14,
  parameter int DIV        = 20,
  parameter int PPM_NARROW = 500,
  parameter int PPM_WIDE   = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ref_i,
  input  logic rst_ni,
  input  logic clk_vco_i,
  input  logic range_wide_i,
  output logic lock_o,
  output logic pd_sel_o
);
  localparam int  CW    = WIN_LOG2 + 2;
  localparam longint WIN = longint'(1) << WIN_LOG2;
  localparam int  TOL_N = int'((WIN * PPM_NARROW) / 1000000);
  localparam int  TOL_W = int'((WIN * PPM_WIDE) / 1000000);

  logic [CW-1:0] vco_gray, vco_bin;
  logic          meas_vld, in_win;
  loop_src_e     src;

  vco_tick_cnt #(.DIV(DIV), .CW(CW)) u_tick (
    .clk_vco_i (clk_vco_i),
    .rst_ni    (rst_ni),
    .gray_o    (vco_gray)
  );

  gray_sync #(.CW(CW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_ref_i),
    .rst_ni (rst_ni),
    .gray_i (vco_gray),
    .bin_o  (vco_bin)
  );

  win_meter #(.WIN_LOG2(WIN_LOG2), .CW(CW), .TOL_N(TOL_N), .TOL_W(TOL_W)) u_meter (
    .clk_i        (clk_ref_i),
    .rst_ni       (rst_ni),
    .vco_bin_i    (vco_bin),
    .range_wide_i (range_wide_i),
    .meas_vld_o   (meas_vld),
    .in_win_o     (in_win)
  );

  lock_fsm u_fsm (
    .clk_i      (clk_ref_i),
    .rst_ni     (rst_ni),
    .meas_vld_i (meas_vld),
    .in_win_i   (in_win),
    .lock_o     (lock_o),
    .src_o      (src)
  );

  assign pd_sel_o = (src == SRC_BB);

  // R1: nothing locked while reset is applied
  always_comb if (!rst_ni) p_reset_idle_r1: assert (!lock_o && !pd_sel_o);
endmodule

// File: tb/sim_freq_lock_det.sv
`timescale 1ns/1fs
module sim_freq_lock_det;
  localparam int WL  = 12;
  localparam int WIN = 1 << WL;

  logic clk = 1'b0, clk_vco = 1'b0, rst_ni = 1'b0, range_wide = 1'b0;
  logic lock, pd_sel;
  real  vco_half = 0.1;
  bit   vco_run = 1'b1;
  int   n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;
  always begin
    if (vco_run) begin
      #(vco_half);
      clk_vco = ~clk_vco;
    end else #1;
  end

  freq_lock_det #(.WIN_LOG2(WL)) u0 (
    .clk_ref_i(clk), .rst_ni(rst_ni), .clk_vco_i(clk_vco),
    .range_wide_i(range_wide), .lock_o(lock), .pd_sel_o(pd_sel)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic set_ppm(input real ppm);
    vco_half = 0.1 / (1.0 + ppm * 1.0e-6);
  endtask

  task automatic step(input int n);
    repeat (n * WIN) @(negedge clk);
  endtask

  task automatic t_reset;
    #7;
    chk(lock, 1'b0, "R1", "lock in reset");
    chk(pd_sel, 1'b0, "R1", "sel in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (WIN / 2) @(negedge clk);   // mid window 0
    chk(lock, 1'b0, "R1", "lock after release");
    chk(pd_sel, 1'b0, "R1", "sel after release");
  endtask

  task automatic t_nominal;          // window 0 discarded, 1 and 2 pass
    step(2);
    chk(lock, 1'b0, "R3", "one pass only");
    step(1);
    chk(lock, 1'b1, "R2", "nominal lock");
    chk(pd_sel, 1'b1, "R7", "data detector when locked");
  endtask

  task automatic t_narrow_plus;      // +1000 ppm, narrow
    set_ppm(1000.0);
    step(2);
    chk(lock, 1'b0, "R5", "+1000 narrow drops");
    chk(pd_sel, 1'b0, "R7", "reference comparator when unlocked");
    for (int i = 0; i < 3; i++) begin
      step(1);
      chk(lock, 1'b0, "R5", "+1000 narrow stays out");
    end
  endtask

  task automatic t_wide_plus;
    range_wide = 1'b1;
    step(2);
    chk(lock, 1'b1, "R6", "+1000 wide locks");
  endtask

  task automatic t_range_switch;
    range_wide = 1'b0;
    step(1);
    chk(lock, 1'b0, "R10", "narrow at next verdict");
  endtask

  task automatic t_minus;
    set_ppm(-1000.0);
    step(3);
    chk(lock, 1'b0, "R9", "-1000 narrow out");
    range_wide = 1'b1;
    step(2);
    chk(lock, 1'b1, "R9", "-1000 wide in");
  endtask

  task automatic t_big_and_relock;
    set_ppm(5000.0);
    step(1);
    chk(lock, 1'b0, "R4", "single failing verdict clears");
    step(1);
    chk(pd_sel, 1'b0, "R4", "back on reference comparator");
    set_ppm(0.0);
    range_wide = 1'b0;
    step(2);
    chk(lock, 1'b0, "R8", "one pass after loss not enough");
    step(1);
    chk(lock, 1'b1, "R8", "relock after two passes");
  endtask

  task automatic t_stopped;
    vco_run = 1'b0;
    step(1);
    chk(lock, 1'b0, "R11", "stopped clock clears");
    step(2);
    chk(lock, 1'b0, "R11", "stopped clock stays out");
    chk(pd_sel, 1'b0, "R11", "sel with stopped clock");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_nominal();
        t_narrow_plus();
        t_wide_plus();
        t_range_switch();
        t_minus();
        t_big_and_relock();
        t_stopped();
      end
      begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule